// File: doc/BRIEF.md
# Chained DMA Channel Sequencer

This block keeps the per-channel programming for a small group of logical DMA channels and decides which of them is enabled at any moment. Each channel has a control word, a link word and a frame count, and software writes them through one write port. Software starts a chain by setting the enable flag of its first channel. The remaining channels of the chain are left disabled, and each one becomes enabled by hardware when its predecessor has moved its whole block of frames.

A separate transfer engine does the data movement. The sequencer asks it for one frame at a time through a per-channel frame strobe and counts the frame-done pulses it sends back. An unsynchronized channel asks for its next frame as soon as it is enabled and idle. A hardware-synchronized channel asks only when an external request arrives. Completing a channel does not force the linked channel to run. It only enables that channel, and the channel's own mode then decides when it moves. A channel that links back to an earlier channel makes the chain repeat without end.

Top module: `chain_seq`

## Requirements
- R1: After reset every channel is inactive, all frame counters read 0, and no start or frame strobe is asserted.
- R2: A write to a channel's control word (select 0) with bit 7 set enables an inactive channel at that clock edge. From the next cycle, ch_active is 1, ch_start pulses for exactly one cycle, and frames_left holds the programmed frame count (select 2).
- R3: An enabled channel in unsynchronized mode (control bit 0 clear) with frames remaining pulses frame_go one cycle after it becomes idle. Only one frame is outstanding at a time, and no new frame_go appears before frame_done.
- R4: In hardware-synchronized mode (control bit 0 set), frame_go pulses the cycle after xfer_req is sampled while the channel is enabled and idle. A request that arrives while the channel is disabled is dropped and is not stored.
- R5: frames_left decreases by one for each frame_done that arrives while a frame is outstanding. A frame_done with no outstanding frame has no effect.
- R6: One cycle after frames_left reaches 0 with no frame outstanding, the channel becomes inactive. If bit 15 of its link word (select 1) is set and the low bits name a channel below the channel count, that channel becomes active at the same edge, its frame count is reloaded and its ch_start pulses.
- R7: With link bit 15 clear, completion leaves every channel inactive and the chain stops.
- R8: A channel enabled by a link while in hardware-synchronized mode issues no frame until a request arrives.
- R9: A link from the last channel back to the first re-enables the first channel, so the chain runs again.
- R10: A software control write to a channel in the same cycle that a link would enable it takes priority. The written enable value is the one that holds.
- R11: Writing 0 to bit 7 of an active channel disables it at once and cancels any frame about to be issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | $clog2(NCH) | Channel addressed by the write |
| cfg_sel | input | 2 | Word select: 0 control, 1 link, 2 frame count |
| cfg_wdata | input | 16 | Write data |
| xfer_req | input | NCH | Per-channel external request event |
| frame_done | input | NCH | Per-channel frame completion from the engine |
| ch_start | output | NCH | One-cycle pulse when a channel is enabled |
| frame_go | output | NCH | One-cycle pulse asking the engine for one frame |
| ch_active | output | NCH | Channel enable state |
| frames_left | output | NCH*FRW | Frames still to move, FRW bits per channel |

## Verification
If a channel keeps a stale outstanding-frame flag, its frame_go stops, and the port shows this within one cycle of the frame_done that should have freed it. A wrong link decode shows on ch_active at the completion edge, because the wrong channel comes up or no channel does, one cycle after frames_left reaches zero. A wrong priority between a software write and a link shows on that same edge, where the written channel comes up active or stays inactive against the value that was written.

// File: rtl/chain_pkg.sv
package chain_pkg;
    localparam int DATA_W        = 16;
    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_SYNC_BIT = 0;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_LINK  = 2'd1,
        SEL_COUNT = 2'd2
    } reg_sel_e;

    // bit 15 enables the link, the low bits name the next channel
    typedef struct packed {
        logic        en;
        logic [14:0] target;
    } link_t;

    function automatic logic link_hits(link_t l, int idx);
        return l.en && (l.target == 15'(idx));
    endfunction
endpackage

// File: rtl/chan_slot.sv
module chain_slot
    import chain_pkg::*;
#(
    parameter int FRW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_link,
    input  logic              wr_count,
    input  logic [DATA_W-1:0] wdata,
    input  logic              arm,
    input  logic              req,
    input  logic              fdone,
    output logic              en,
    output logic              start,
    output logic              go,
    output logic [FRW-1:0]    left,
    output logic              finish,
    output link_t             link
);
    logic           mode;
    logic           busy;
    logic [FRW-1:0] cfg;
    logic           issue;

    assign finish = en && !busy && (left == '0) && !wr_ctrl;
    assign issue  = en && !busy && (left != '0) && (!mode || req);

    always_ff @(posedge clk) begin
        if (rst) begin
            en    <= 1'b0;
            mode  <= 1'b0;
            busy  <= 1'b0;
            start <= 1'b0;
            go    <= 1'b0;
            left  <= '0;
            cfg   <= '0;
            link  <= '0;
        end else begin
            start <= 1'b0;
            go    <= 1'b0;
            if (wr_count) cfg <= wdata[FRW-1:0];
            if (wr_link)  link <= link_t'(wdata);
            if (busy && fdone) begin
                busy <= 1'b0;
                left <= left - FRW'(1);
            end
            if (issue) begin
                busy <= 1'b1;
                go   <= 1'b1;
            end
            if (finish) en <= 1'b0;
            if (arm) begin
                en    <= 1'b1;
                left  <= cfg;
                start <= 1'b1;
                busy  <= 1'b0;
                go    <= 1'b0;
            end
            if (wr_ctrl) begin
                mode <= wdata[CTRL_SYNC_BIT];
                en   <= wdata[CTRL_EN_BIT];
                if (!wdata[CTRL_EN_BIT]) begin
                    busy  <= 1'b0;
                    go    <= 1'b0;
                    start <= 1'b0;
                end else if (!en && !arm) begin
                    left  <= cfg;
                    start <= 1'b1;
                    busy  <= 1'b0;
                    go    <= 1'b0;
                end
            end
        end
    end

    p_busy_needs_en_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> en);
    p_go_single_r3: assert property (@(posedge clk) disable iff (rst)
        go |=> !go);
    p_sync_waits_r4: assert property (@(posedge clk) disable iff (rst)
        (go && $past(mode)) |-> $past(req));
    p_left_step_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && fdone && !arm && !wr_ctrl) |=> (left == $past(left) - FRW'(1)));
    p_finish_drops_r6: assert property (@(posedge clk) disable iff (rst)
        (finish && !arm) |=> !en);
    p_start_active_r2: assert property (@(posedge clk) disable iff (rst)
        start |-> en);
endmodule

// File: rtl/link_router.sv
module link_router
    import chain_pkg::*;
#(
    parameter int NCH = 4
) (
    input  link_t [NCH-1:0] links,
    input  logic  [NCH-1:0] finish,
    output logic  [NCH-1:0] arm
);
    always_comb begin
        arm = '0;
        for (int i = 0; i < NCH; i++) begin
            for (int j = 0; j < NCH; j++) begin
                if (finish[i] && link_hits(links[i], j)) arm[j] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/chain_seq.sv
module chain_seq
    import chain_pkg::*;
#(
    parameter int NCH = 4,
    parameter int FRW = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CHW-1:0]     cfg_ch,
    input  logic [1:0]         cfg_sel,
    input  logic [15:0]        cfg_wdata,
    input  logic [NCH-1:0]     xfer_req,
    input  logic [NCH-1:0]     frame_done,
    output logic [NCH-1:0]     ch_start,
    output logic [NCH-1:0]     frame_go,
    output logic [NCH-1:0]     ch_active,
    output logic [NCH*FRW-1:0] frames_left
);
    link_t [NCH-1:0] links;
    logic  [NCH-1:0] finish;
    logic  [NCH-1:0] arm;
    reg_sel_e        sel;

    assign sel = reg_sel_e'(cfg_sel);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = cfg_we && (cfg_ch == CHW'(g));

        chain_slot #(.FRW(FRW)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_ctrl  (hit && sel == SEL_CTRL),
            .wr_link  (hit && sel == SEL_LINK),
            .wr_count (hit && sel == SEL_COUNT),
            .wdata    (cfg_wdata),
            .arm      (arm[g]),
            .req      (xfer_req[g]),
            .fdone    (frame_done[g]),
            .en       (ch_active[g]),
            .start    (ch_start[g]),
            .go       (frame_go[g]),
            .left     (frames_left[g*FRW +: FRW]),
            .finish   (finish[g]),
            .link     (links[g])
        );
    end

    link_router #(.NCH(NCH)) u_router (
        .links  (links),
        .finish (finish),
        .arm    (arm)
    );
endmodule

// File: tb/chain_seq_bench.sv
module chain_seq_bench;
    localparam int NCH = 4;
    localparam int FRW = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_we = 1'b0;
    logic [1:0]         cfg_ch = '0;
    logic [1:0]         cfg_sel = '0;
    logic [15:0]        cfg_wdata = '0;
    logic [NCH-1:0]     xfer_req = '0;
    logic [NCH-1:0]     frame_done = '0;
    logic [NCH-1:0]     ch_start, frame_go, ch_active;
    logic [NCH*FRW-1:0] frames_left;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    chain_seq #(.NCH(NCH), .FRW(FRW)) u_chain_seq (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .xfer_req(xfer_req),
        .frame_done(frame_done), .ch_start(ch_start), .frame_go(frame_go),
        .ch_active(ch_active), .frames_left(frames_left)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int left_of(int ch);
        return int'(frames_left[ch*FRW +: FRW]);
    endfunction

    task automatic wreg(int ch, int sel, int data);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = 16'(data);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic wait_go(int ch);
        for (int k = 0; k < 20; k++) begin
            if (frame_go[ch]) return;
            tick();
        end
        chk("R3", "frame_go never seen", 0, 1);
    endtask

    task automatic serve(int ch);
        wait_go(ch);
        frame_done[ch] = 1'b1;
        tick();
        frame_done[ch] = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "active after reset", int'(ch_active), 0);
        chk("R1", "frames_left after reset", int'(frames_left), 0);
        chk("R1", "strobes after reset", int'(frame_go | ch_start), 0);
    endtask

    task automatic t_single();
        wreg(0, 2, 3); wreg(0, 1, 0); wreg(0, 0, 16'h0080);
        chk("R2", "ch0 active", int'(ch_active[0]), 1);
        chk("R2", "ch0 start", int'(ch_start[0]), 1);
        chk("R2", "ch0 count loaded", left_of(0), 3);
        tick();
        chk("R2", "start is one pulse", int'(ch_start[0]), 0);
        chk("R3", "go after enable", int'(frame_go[0]), 1);
        tick(); tick();
        chk("R3", "no second go while outstanding", int'(frame_go[0]), 0);
        frame_done[0] = 1'b1;
        tick();
        chk("R5", "decrement on done", left_of(0), 2);
        tick();
        frame_done[0] = 1'b0;
        chk("R5", "stray done ignored", left_of(0), 2);
        chk("R3", "go reissued", int'(frame_go[0]), 1);
        frame_done[0] = 1'b1; tick(); frame_done[0] = 1'b0;
        chk("R5", "second decrement", left_of(0), 1);
        serve(0);
        chk("R6", "still active at zero", int'(ch_active[0]), 1);
        tick();
        chk("R6", "ch0 done", int'(ch_active[0]), 0);
        chk("R7", "no channel active", int'(ch_active), 0);
    endtask

    task automatic t_link_sync();
        wreg(1, 2, 2); wreg(1, 1, 16'h8002);
        wreg(2, 2, 1); wreg(2, 1, 0); wreg(2, 0, 16'h0001);
        xfer_req[2] = 1'b1; tick(); xfer_req[2] = 1'b0; tick();
        chk("R4", "req to disabled ignored", int'(frame_go[2]), 0);
        chk("R4", "disabled stays idle", int'(ch_active[2]), 0);
        wreg(1, 0, 16'h0080);
        serve(1); serve(1);
        chk("R5", "ch1 drained", left_of(1), 0);
        tick();
        chk("R6", "ch1 released", int'(ch_active[1]), 0);
        chk("R6", "ch2 linked on", int'(ch_active[2]), 1);
        chk("R6", "ch2 start", int'(ch_start[2]), 1);
        chk("R6", "ch2 reloaded", left_of(2), 1);
        tick(); tick(); tick();
        chk("R8", "synced link waits", int'(frame_go[2]), 0);
        xfer_req[2] = 1'b1; tick(); xfer_req[2] = 1'b0;
        chk("R4", "go after request", int'(frame_go[2]), 1);
        frame_done[2] = 1'b1; tick(); frame_done[2] = 1'b0;
        tick();
        chk("R7", "chain stopped", int'(ch_active), 0);
    endtask

    task automatic t_loop_abort();
        wreg(3, 2, 1); wreg(3, 1, 16'h8000); wreg(3, 0, 0);
        wreg(0, 2, 1); wreg(0, 1, 16'h8003); wreg(0, 0, 16'h0080);
        serve(0);
        tick();
        chk("R6", "ch3 follows ch0", int'(ch_active), 8);
        chk("R6", "ch3 start", int'(ch_start[3]), 1);
        serve(3);
        tick();
        chk("R9", "loop back to ch0", int'(ch_active), 1);
        chk("R9", "ch0 restarted", int'(ch_start[0]), 1);
        wreg(0, 0, 0);
        chk("R11", "abort clears", int'(ch_active[0]), 0);
        chk("R11", "abort cancels go", int'(frame_go[0]), 0);
        tick(); tick();
        chk("R11", "no go after abort", int'(frame_go), 0);
        chk("R11", "all idle", int'(ch_active), 0);
    endtask

    task automatic t_priority();
        wreg(1, 2, 1); wreg(1, 1, 16'h8002); wreg(2, 0, 0);
        wreg(1, 0, 16'h0080);
        serve(1);
        chk("R5", "ch1 at zero", left_of(1), 0);
        wreg(2, 0, 16'h0001);
        chk("R10", "ch1 completed", int'(ch_active[1]), 0);
        chk("R10", "write beats link", int'(ch_active[2]), 0);
        chk("R10", "no start on ch2", int'(ch_start[2]), 0);
        tick();
        chk("R10", "nothing active", int'(ch_active), 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        summary();
    end

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_single();
        t_link_sync();
        t_loop_abort();
        t_priority();
        summary();
    end
endmodule